// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a slave has left stuck partway through a byte, whether the slave was reading or writing at the time. A one-cycle request starts a fixed train of nine recovery cycles on the two open-drain lines. Each cycle opens with a short master-active phase and then leaves the bus alone for a longer idle phase. The master-active phase issues a START condition followed by one SCL low pulse. Nine cycles cover the eight data bits and the acknowledge bit, so a slave stuck at any bit position sees enough clocks to finish its byte. The START in every cycle also resets a slave that was waiting for more write data.

The timing unit scales with the bus rate, which is supplied in kHz. The unit in microseconds is one bus period rounded down plus one, and it is never less than 2. A prescaler turns a count of system clocks per microsecond into a microsecond tick. Both configuration values are captured when a request is accepted. The lines are only ever pulled low through output enables and are never driven high. The START step waits while another device holds SCL low.

Top module: `bus_unstick`

## Requirements
- R1: A `start_i` pulse seen while idle raises `busy_o` on the next clock edge, and the first microsecond of the run begins on that edge.
- R2: A run contains exactly 9 recovery cycles. Each cycle begins with a START condition: `sda_oe_o` rises while `scl_oe_o` is low.
- R3: Within a cycle of 3·U microseconds, counted from 0: `sda_oe_o` is high for microseconds 0 to U−2, `scl_oe_o` is high for microseconds 1 to U−1, and both are low for the remaining 2·U microseconds.
- R4: U = floor(1000 / `bus_khz_i`) + 1, with a minimum of 2. For example, 375 gives 3 and 1000 gives 2.
- R5: One microsecond lasts `clk_per_us_i` clocks, and a value of 0 is treated as 1. An unstalled run therefore lasts 27·U·`clk_per_us_i` clocks.
- R6: When the last cycle ends, `busy_o` falls and `done_o` is high for exactly one clock. Both enables stay low while idle.
- R7: A `start_i` pulse seen while `busy_o` is high has no effect on the waveform or on the run length.
- R8: Changes to `bus_khz_i` or `clk_per_us_i` while `busy_o` is high do not affect the run in progress.
- R9: At the start of each cycle, while the synchronised `scl_i` reads low, both enables stay low and the timing does not advance. Timing resumes one full microsecond after SCL is seen high.
- R10: SDA changes only while the block holds SCL low, except at the START edge, and SCL is released only after SDA has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle recovery request |
| bus_khz_i | input | KHZ_W (10) | Bus rate in kHz, used to derive the timing unit |
| clk_per_us_i | input | DIV_W (10) | System clocks per microsecond |
| scl_i | input | 1 | Level sensed on the SCL line |
| scl_oe_o | output | 1 | Pull SCL low when high |
| sda_oe_o | output | 1 | Pull SDA low when high |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-clock pulse when the run completes |

## Verification
The line-ordering assertions assume that no other device pulls SCL low once a cycle's START step has begun. Clock stretching is expected only before the START, where the block waits for it. The bench models the bus as pulled up, with SCL read back as the inverse of the block's own enable. It adds an external hold only before a run begins, and removes it before the block would issue its first START. Random rates between 100 and 1023 kHz keep the unit between 2 and 11 microseconds, and random prescale values between 1 and 4 keep each run short. Mid-run request pulses and configuration changes are placed well inside a run, never on its final edge.

// File: rtl/bus_unstick_pkg.sv
`timescale 1ns/1ps
package bus_unstick_pkg;
  localparam int unsigned KHZ_PER_MHZ  = 1000;
  localparam int unsigned UNIT_MIN     = 2;
  localparam int unsigned UNITS_PER_CYC = 3;
endpackage

// File: rtl/rcv_unit_calc.sv
`timescale 1ns/1ps
module rcv_unit_calc import bus_unstick_pkg::*; #(
  parameter int unsigned KHZ_W  = 10,
  parameter int unsigned UNIT_W = 10
) (
  input  logic [KHZ_W-1:0]  khz_i,
  output logic [UNIT_W-1:0] unit_o
);
  logic [31:0] khz_safe;
  logic [31:0] quo;

  always_comb begin
    khz_safe = (khz_i == '0) ? 32'd1 : 32'(khz_i);
    quo      = KHZ_PER_MHZ / khz_safe + 32'd1;
    if (quo < UNIT_MIN) unit_o = UNIT_W'(UNIT_MIN);
    else                unit_o = UNIT_W'(quo);
  end

  always_comb begin
    a_r4_unit_floor: assert (unit_o >= UNIT_W'(UNIT_MIN));
  end
endmodule

// File: rtl/rcv_us_tick.sv
`timescale 1ns/1ps
module rcv_us_tick #(
  parameter int unsigned DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == div_i - DIV_W'(1));
  assign tick_o = run_i && !hold_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i || hold_i || wrap) cnt_q <= '0;
    else                              cnt_q <= cnt_q + DIV_W'(1);
  end

  a_r5_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < div_i));
  a_r9_hold_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0));
endmodule

// File: rtl/rcv_step_seq.sv
`timescale 1ns/1ps
module rcv_step_seq import bus_unstick_pkg::*; #(
  parameter int unsigned NUM_CYC = 9,
  parameter int unsigned UNIT_W  = 10,
  parameter int unsigned POS_W   = 12,
  parameter int unsigned CYC_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic [UNIT_W-1:0] unit_i,
  input  logic              scl_hi_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              stall_o,
  output logic              sda_oe_o,
  output logic              scl_oe_o
);
  logic              busy_q, done_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [POS_W-1:0]  pos_q;
  logic [UNIT_W-1:0] unit_q;
  logic [POS_W-1:0]  unit_w, last_pos;

  assign unit_w   = POS_W'(unit_q);
  assign last_pos = unit_w + unit_w + unit_w - POS_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cyc_q  <= '0;
      pos_q  <= '0;
      unit_q <= UNIT_W'(UNIT_MIN);
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          cyc_q  <= '0;
          pos_q  <= '0;
          unit_q <= unit_i;
        end
      end else if (tick_i) begin
        if (pos_q == last_pos) begin
          pos_q <= '0;
          if (cyc_q == CYC_W'(NUM_CYC - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            cyc_q  <= '0;
          end else begin
            cyc_q <= cyc_q + CYC_W'(1);
          end
        end else begin
          pos_q <= pos_q + POS_W'(1);
        end
      end
    end
  end

  // START step waits for SCL to read high before pulling SDA
  assign stall_o  = busy_q && (pos_q == '0) && !scl_hi_i;
  assign sda_oe_o = busy_q && ((pos_q == '0) ? scl_hi_i : (pos_q < unit_w - POS_W'(1)));
  assign scl_oe_o = busy_q && (pos_q != '0) && (pos_q < unit_w);
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  a_r1_busy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && start_i) |=> (busy_q && pos_q == '0 && cyc_q == '0));
  a_r2_cyc_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cyc_q < CYC_W'(NUM_CYC)));
  a_r2_start_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_oe_o);
  a_r10_sda_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> scl_oe_o);
  a_r10_scl_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_oe_o) |-> !sda_oe_o);
  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r6_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (!sda_oe_o && !scl_oe_o));
  a_r8_unit_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> $stable(unit_q));
  a_r7_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick_i) |=> ($stable(pos_q) && $stable(cyc_q)));
endmodule

// File: rtl/bus_unstick.sv
`timescale 1ns/1ps
module bus_unstick import bus_unstick_pkg::*; #(
  parameter int unsigned KHZ_W       = 10,
  parameter int unsigned DIV_W       = 10,
  parameter int unsigned NUM_CYC     = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [KHZ_W-1:0] bus_khz_i,
  input  logic [DIV_W-1:0] clk_per_us_i,
  input  logic             scl_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned UNIT_MAX = KHZ_PER_MHZ + 1;
  localparam int unsigned UNIT_W   = $clog2(UNIT_MAX + 1);
  localparam int unsigned POS_W    = $clog2(UNITS_PER_CYC * UNIT_MAX);
  localparam int unsigned CYC_W    = $clog2(NUM_CYC + 1);

  logic [UNIT_W-1:0] unit;
  logic [DIV_W-1:0]  div_q;
  logic              tick, stall, busy, scl_hi;
  logic [SYNC_STAGES-1:0] scl_sync_q;

  // input synchroniser, depth chosen by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) scl_sync_q <= '1;
        else         scl_sync_q <= scl_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) scl_sync_q <= '1;
        else         scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
      end
    end
  endgenerate
  assign scl_hi = scl_sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               div_q <= DIV_W'(1);
    else if (!busy && start_i) div_q <= (clk_per_us_i == '0) ? DIV_W'(1) : clk_per_us_i;
  end

  rcv_unit_calc #(.KHZ_W(KHZ_W), .UNIT_W(UNIT_W)) u_unit (
    .khz_i  (bus_khz_i),
    .unit_o (unit)
  );

  rcv_us_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .hold_i (stall),
    .div_i  (div_q),
    .tick_o (tick)
  );

  rcv_step_seq #(.NUM_CYC(NUM_CYC), .UNIT_W(UNIT_W), .POS_W(POS_W), .CYC_W(CYC_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .tick_i   (tick),
    .unit_i   (unit),
    .scl_hi_i (scl_hi),
    .busy_o   (busy),
    .done_o   (done_o),
    .stall_o  (stall),
    .sda_oe_o (sda_oe_o),
    .scl_oe_o (scl_oe_o)
  );

  assign busy_o = busy;

  a_r8_div_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(div_q));
endmodule

// File: tb/tb_bus_unstick.sv
`timescale 1ns/1ps
module tb_bus_unstick;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [9:0] bus_khz_i = 10'd375;
  logic [9:0] clk_per_us_i = 10'd1;
  logic       hold_ext = 1'b0;
  logic       scl_i;
  logic       scl_oe_o, sda_oe_o, busy_o, done_o;
  int         total = 0;
  int         bad = 0;
  bit         ended = 1'b0;

  always #2 clk_i = ~clk_i;

  // pulled-up bus: line low when anyone pulls it
  assign scl_i = !(scl_oe_o || hold_ext);

  bus_unstick dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .bus_khz_i(bus_khz_i), .clk_per_us_i(clk_per_us_i), .scl_i(scl_i),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int unit_of(input int khz);
    int u;
    u = 1000 / ((khz == 0) ? 1 : khz) + 1;
    return (u < 2) ? 2 : u;
  endfunction

  // ideal bus run; poke adds a mid-run request and config change
  task automatic run_seq(input int khz, input int p, input bit poke);
    int u, t, r, wave_bad, starts, first_bad_k;
    bit prev_sda, e_sda, e_scl;
    u = unit_of(khz);
    t = 27 * u * p;
    wave_bad = 0; starts = 0; prev_sda = 0; first_bad_k = -1;
    bus_khz_i = 10'(khz); clk_per_us_i = 10'(p);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R1 busy after request", int'(busy_o), 1);
    for (int k = 0; k < t; k++) begin
      r = (k / p) % (3 * u);
      e_sda = (r < u - 1);
      e_scl = (r >= 1) && (r < u);
      if (sda_oe_o !== e_sda || scl_oe_o !== e_scl || busy_o !== 1'b1 || done_o !== 1'b0) begin
        if (first_bad_k < 0) first_bad_k = k;
        wave_bad++;
      end
      if (sda_oe_o && !prev_sda && !scl_oe_o) starts++;
      prev_sda = sda_oe_o;
      if (poke && k == t / 3) begin
        start_i = 1'b1;
        bus_khz_i = 10'($urandom_range(100, 1023));
        clk_per_us_i = 10'($urandom_range(1, 4));
      end
      if (poke && k == t / 3 + 1) start_i = 1'b0;
      @(negedge clk_i);
    end
    if (poke)
      chk(wave_bad == 0, "R7/R8 waveform unchanged by mid-run request and config", first_bad_k, -1);
    else
      chk(wave_bad == 0, "R3/R4/R5 waveform per unit and prescale", first_bad_k, -1);
    chk(starts == 9, "R2 START count", starts, 9);
    chk(busy_o == 1'b0 && done_o == 1'b1, "R6 end of run busy low done high",
        {30'd0, busy_o, done_o}, 1);
    @(negedge clk_i);
    chk(done_o == 1'b0 && !sda_oe_o && !scl_oe_o && !busy_o, "R6 done one clock and lines released",
        {28'd0, done_o, sda_oe_o, scl_oe_o, busy_o}, 0);
  endtask

  task automatic run_hold(input int h);
    int u, t, k, hold_bad;
    u = unit_of(375);
    t = 27 * u * 2;
    hold_bad = 0;
    bus_khz_i = 10'd375; clk_per_us_i = 10'd2;
    hold_ext = 1'b1;
    repeat (4) @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int j = 0; j < h; j++) begin
      if (!busy_o || sda_oe_o || scl_oe_o) hold_bad++;
      @(negedge clk_i);
    end
    chk(hold_bad == 0, "R9 lines released while SCL held low", hold_bad, 0);
    hold_ext = 1'b0;
    k = h;
    while (!done_o && k < t + h + 40) begin
      @(negedge clk_i);
      k++;
    end
    chk(k >= t + h + 1 && k <= t + h + 3, "R9 run extended by hold", k, t + h + 2);
    @(negedge clk_i);
  endtask

  initial begin
    void'($urandom(32'd1337));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !sda_oe_o && !scl_oe_o, "R6 reset idle",
        {28'd0, busy_o, done_o, sda_oe_o, scl_oe_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!sda_oe_o && !scl_oe_o, "R6 idle lines released", {30'd0, sda_oe_o, scl_oe_o}, 0);
    // directed corners
    run_seq(375, 1, 1'b0);   // U=3
    run_seq(1000, 2, 1'b0);  // U=2
    run_seq(1023, 1, 1'b0);  // R4 floor: quotient 0 gives 2
    run_seq(100, 3, 1'b0);   // U=11
    run_seq(500, 4, 1'b1);
    clk_per_us_i = 10'd0;    // R5 zero treated as one
    bus_khz_i = 10'd375;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int k = 0; k < 81 && !done_o; k++) @(negedge clk_i);
    chk(done_o == 1'b1, "R5 zero prescale behaves as one", int'(done_o), 1);
    repeat (2) @(negedge clk_i);
    for (int i = 0; i < 10; i++)
      run_seq($urandom_range(100, 1023), $urandom_range(1, 4), i[0]);
    run_hold(10);
    run_hold(3);
    ended = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!ended) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule